// File: doc/BRIEF.md
# Byte-serial AES-128 encryption core

This block encrypts one 128-bit block under a 128-bit key with AES-128, ten rounds. Every byte operation goes through one 8-bit datapath. The cipher state sits in a 16-entry byte memory and the key sits in a second 16-entry byte memory. A single S-box serves both the state substitution and the key expansion. MixColumns is computed one output byte at a time from a 4-byte column buffer.

The round keys are not stored. Each one is derived in place from the previous one while the encryption runs, so a fresh key can be written before every block. ShiftRows moves no data. The core keeps a 2-bit row-rotation count and folds it into every state-memory address, so each byte stays where it is and is read and written at a remapped location.

Software writes the key and the plaintext byte by byte while the core is idle, then pulses start. When ready returns high, it reads the ciphertext one byte at a time through a combinational read port. The key memory holds the last round key after a run, so the key is written again before the next block.

Top module: `aes_byte_core`

## Requirements
- R1: After a synchronous reset, ready is 1 and the core is idle.
- R2: A start pulse sampled while ready is 1 drives ready to 0. Ready returns to 1 exactly 640 clock cycles after the edge that sampled start.
- R3: With key 000102030405060708090a0b0c0d0e0f and plaintext 00112233445566778899aabbccddeeff, the ciphertext is 69c4e0d86a7b0430d8cdb78070b4c55a.
- R4: The result is the standard AES-128 ciphertext for other key and plaintext pairs. Key 2b7e151628aed2a6abf7158809cf4f3c with plaintext 3243f6a8885a308d313198a2e0370734 gives 3925841d02dc09fbdc118597196a0b32. An all-zero key with an all-zero plaintext gives 66e94bd4ef8a2c3b884cfa59ca342b2e.
- R5: Encryptions run back to back, each with a freshly written key, and each gives the correct ciphertext for its own key.
- R6: Writes to the key memory or the plaintext memory are ignored while ready is 0. The ciphertext of the running block is unchanged by them.
- R7: A start pulse while ready is 0 is ignored. The running block keeps its 640-cycle latency and its correct ciphertext.
- R8: Byte i (0 to 15) of a 128-bit value is the i-th byte from the most significant end. Byte i sits at column i/4 and row i%4 of the state matrix. ld_addr=i writes byte i of the key or plaintext, and rd_addr=i returns byte i of the ciphertext.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin encryption; sampled only while ready is 1 |
| ready | output | 1 | Core is idle and the ciphertext is readable |
| pt_we | input | 1 | Write ld_data into plaintext byte ld_addr, only while ready is 1 |
| key_we | input | 1 | Write ld_data into key byte ld_addr, only while ready is 1 |
| ld_addr | input | 4 | Byte index for loading |
| ld_data | input | 8 | Byte value for loading |
| rd_addr | input | 4 | Ciphertext byte index |
| rd_data | output | 8 | Ciphertext byte rd_addr (combinational) |

## Verification
The bench builds the core with its default ROUNDS value of 10, the only value that gives AES-128. With that value every known-answer vector can be compared, and the fixed 640-cycle latency can be checked for ready. The 2-bit rotation count goes through ten ShiftRows steps, so the final readout uses a non-zero address remap. The rounds before it also pass through every rotation value on their MixColumns reads. Loads and start pulses during a run, and a key swap between consecutive blocks, are the cases that would expose a sequencer or a key schedule that leaks between blocks.

// File: rtl/aes_pkg.sv
package aes_pkg;

    localparam int BYTES = 16;
    localparam int AW    = $clog2(BYTES);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ARK0,
        PH_SUB,
        PH_KEY,
        PH_MIX,
        PH_ARKL
    } phase_e;

    typedef struct packed {
        phase_e     ph;
        logic [4:0] cnt;
        logic [1:0] rot;
        logic [7:0] rcon;
    } seq_t;

    function automatic logic [7:0] xtime(logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gmul(logic [7:0] a, logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] p;
        acc = 8'h00;
        p   = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ p;
            p = xtime(p);
        end
        return acc;
    endfunction

    // x^254 is the multiplicative inverse, with 0 mapping to 0
    function automatic logic [7:0] ginv(logic [7:0] x);
        logic [7:0] r;
        r = 8'h01;
        for (int i = 7; i >= 0; i--) begin
            r = gmul(r, r);
            if (i != 0) r = gmul(r, x);
        end
        return r;
    endfunction

    function automatic logic [7:0] rotl8(logic [7:0] v, int n);
        return (v << n) | (v >> (8 - n));
    endfunction

    function automatic logic [7:0] sbox(logic [7:0] x);
        logic [7:0] b;
        b = ginv(x);
        return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
    endfunction

    // physical location of logical byte after rot ShiftRows steps
    function automatic logic [AW-1:0] phys(logic [AW-1:0] a, logic [1:0] rot);
        logic [3:0] p;
        p = {2'b00, a[1:0]} * {2'b00, rot};
        return {a[3:2] + p[1:0], a[1:0]};
    endfunction

endpackage

// File: rtl/aes_sbox.sv
module aes_sbox
    import aes_pkg::*;
(
    input  logic [7:0] din,
    output logic [7:0] dout
);
    assign dout = sbox(din);
endmodule

// File: rtl/aes_mixcol.sv
module aes_mixcol (
    input  logic [3:0][7:0] col,
    input  logic [1:0]      row,
    output logic [7:0]      dout
);
    import aes_pkg::*;
    logic [7:0] b0, b1, b2, b3;

    always_comb begin
        b0 = col[row];
        b1 = col[row + 2'd1];
        b2 = col[row + 2'd2];
        b3 = col[row + 2'd3];
        dout = xtime(b0) ^ xtime(b1) ^ b1 ^ b2 ^ b3;
    end
endmodule

// File: rtl/aes_ctrl.sv
module aes_ctrl
    import aes_pkg::*;
#(
    parameter int ROUNDS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic ready,
    output seq_t seq
);
    localparam int RW = $clog2(ROUNDS + 1);

    phase_e        ph;
    logic [4:0]    cnt;
    logic [1:0]    rot;
    logic [7:0]    rcon;
    logic [RW-1:0] rnd;
    logic          last16;

    assign last16 = (cnt[3:0] == 4'd15);
    assign ready  = (ph == PH_IDLE);
    assign seq    = '{ph: ph, cnt: cnt, rot: rot, rcon: rcon};

    always_ff @(posedge clk) begin
        if (rst) begin
            ph   <= PH_IDLE;
            cnt  <= '0;
            rot  <= '0;
            rcon <= 8'h01;
            rnd  <= RW'(1);
        end else begin
            cnt <= cnt + 5'd1;
            unique case (ph)
                PH_IDLE: begin
                    cnt <= '0;
                    if (start) begin
                        ph   <= PH_ARK0;
                        rot  <= '0;
                        rcon <= 8'h01;
                        rnd  <= RW'(1);
                    end
                end
                PH_ARK0: if (last16) begin ph <= PH_SUB; cnt <= '0; end
                PH_SUB: if (last16) begin
                    ph  <= PH_KEY;
                    cnt <= '0;
                    rot <= rot + 2'd1;
                end
                PH_KEY: if (last16) begin
                    cnt  <= '0;
                    rcon <= xtime(rcon);
                    ph   <= (rnd == RW'(ROUNDS)) ? PH_ARKL : PH_MIX;
                end
                PH_MIX: if (cnt == 5'd31) begin
                    cnt <= '0;
                    rnd <= rnd + RW'(1);
                    ph  <= PH_SUB;
                end
                PH_ARKL: if (last16) begin ph <= PH_IDLE; cnt <= '0; end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    a_r2_start_accept: assert property (@(posedge clk) disable iff (rst)
        (ready && start) |=> (ph == PH_ARK0 && cnt == 5'd0));

    a_r2_round_range: assert property (@(posedge clk) disable iff (rst)
        !ready |-> (rnd >= RW'(1) && rnd <= RW'(ROUNDS)));

    a_r2_finish: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_ARKL && cnt == 5'd15) |=> ready);

    a_r7_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_MIX && start) |=> !ready);

    a_r3_rot_step: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_SUB && cnt == 5'd15) |=> rot == $past(rot) + 2'd1);

    a_r4_rcon_valid: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_KEY) |-> ($onehot(rcon) || rcon == 8'h1b || rcon == 8'h36));

endmodule

// File: rtl/aes_byte_core.sv
module aes_byte_core
    import aes_pkg::*;
#(
    parameter int ROUNDS = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          ready,
    input  logic          pt_we,
    input  logic          key_we,
    input  logic [AW-1:0] ld_addr,
    input  logic [7:0]    ld_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    seq_t            seq;
    logic [7:0]      st   [BYTES];
    logic [7:0]      kmem [BYTES];
    logic [3:0][7:0] cbuf;

    logic [AW-1:0] idx, pa, col_addr, mpa, ksrc;
    logic [7:0]    sb_in, sb_out, mix_out;

    aes_ctrl #(.ROUNDS(ROUNDS)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .ready(ready), .seq(seq)
    );

    always_comb begin
        idx      = seq.cnt[3:0];
        pa       = phys(idx, seq.rot);
        col_addr = {seq.cnt[4:3], seq.cnt[1:0]};
        mpa      = phys(col_addr, seq.rot);
        ksrc     = {2'b11, seq.cnt[1:0] + 2'd1};
        sb_in    = (seq.ph == PH_KEY) ? kmem[ksrc] : st[idx];
    end

    aes_sbox u_sbox (.din(sb_in), .dout(sb_out));

    aes_mixcol u_mix (.col(cbuf), .row(seq.cnt[1:0]), .dout(mix_out));

    assign rd_data = st[phys(rd_addr, seq.rot)];

    always_ff @(posedge clk) begin
        unique case (seq.ph)
            PH_IDLE: begin
                if (pt_we)  st[ld_addr]   <= ld_data;
                if (key_we) kmem[ld_addr] <= ld_data;
            end
            PH_ARK0, PH_ARKL: st[pa] <= st[pa] ^ kmem[idx];
            PH_SUB: st[idx] <= sb_out;
            PH_KEY: begin
                if (idx < 4'd4)
                    kmem[idx] <= kmem[idx] ^ sb_out ^ ((idx == 4'd0) ? seq.rcon : 8'h00);
                else
                    kmem[idx] <= kmem[idx] ^ kmem[idx - 4'd4];
            end
            PH_MIX: begin
                if (!seq.cnt[2]) cbuf[seq.cnt[1:0]] <= st[mpa];
                else             st[mpa] <= mix_out ^ kmem[col_addr];
            end
            default: ;
        endcase
    end

endmodule

// File: tb/aes_byte_core_test.sv
`timescale 1ns/1ps
module aes_byte_core_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       ready;
    logic       pt_we = 1'b0;
    logic       key_we = 1'b0;
    logic [3:0] ld_addr = '0;
    logic [7:0] ld_data = '0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam int LAT = 640;

    always #2 clk = ~clk;

    aes_byte_core uut (
        .clk(clk), .rst(rst), .start(start), .ready(ready),
        .pt_we(pt_we), .key_we(key_we), .ld_addr(ld_addr), .ld_data(ld_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check128(string tag, logic [127:0] act, logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_int(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // R8: byte i is taken from the most significant end
    task automatic load_block(logic [127:0] key, logic [127:0] pt);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            key_we = 1'b1; ld_addr = 4'(i); ld_data = key[127 - 8*i -: 8];
        end
        @(negedge clk); key_we = 1'b0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            pt_we = 1'b1; ld_addr = 4'(i); ld_data = pt[127 - 8*i -: 8];
        end
        @(negedge clk); pt_we = 1'b0;
    endtask

    task automatic kick(output int cycles);
        @(negedge clk); start = 1'b1;
        @(posedge clk); #1; start = 1'b0;
        cycles = 0;
        while (!ready && cycles < 5000) begin
            @(posedge clk); #1; cycles++;
        end
    endtask

    task automatic read_ct(output logic [127:0] ct);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk); rd_addr = 4'(i); #1;
            ct[127 - 8*i -: 8] = rd_data;
        end
    endtask

    task automatic run_vec(string tag, logic [127:0] key, logic [127:0] pt,
                           logic [127:0] exp, bit chk_lat);
        int cyc;
        logic [127:0] ct;
        load_block(key, pt);
        kick(cyc);
        if (chk_lat) check_int({tag, " R2 latency"}, cyc, LAT);
        read_ct(ct);
        check128({tag, " ciphertext"}, ct, exp);
    endtask

    task automatic test_reset();
        @(negedge clk);
        check_int("R1 ready after reset", int'(ready), 1);
    endtask

    task automatic test_back_to_back();
        run_vec("R5 block A", 128'h2b7e151628aed2a6abf7158809cf4f3c,
                128'h3243f6a8885a308d313198a2e0370734,
                128'h3925841d02dc09fbdc118597196a0b32, 1'b0);
        run_vec("R5 block B", 128'h000102030405060708090a0b0c0d0e0f,
                128'h00112233445566778899aabbccddeeff,
                128'h69c4e0d86a7b0430d8cdb78070b4c55a, 1'b0);
    endtask

    task automatic test_busy_loads();
        int cyc;
        logic [127:0] ct;
        load_block(128'h000102030405060708090a0b0c0d0e0f,
                   128'h00112233445566778899aabbccddeeff);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            pt_we = 1'b1; key_we = 1'b1; ld_addr = 4'(i); ld_data = 8'hA5 ^ 8'(i);
        end
        @(negedge clk); pt_we = 1'b0; key_we = 1'b0;
        cyc = 0;
        while (!ready && cyc < 5000) begin @(negedge clk); cyc++; end
        check_int("R6 ready after busy loads", int'(ready), 1);
        read_ct(ct);
        check128("R6 busy loads ignored", ct, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    endtask

    task automatic test_busy_start();
        int cyc;
        logic [127:0] ct;
        load_block(128'h2b7e151628aed2a6abf7158809cf4f3c,
                   128'h3243f6a8885a308d313198a2e0370734);
        @(negedge clk); start = 1'b1;
        @(posedge clk); #1; start = 1'b0;
        cyc = 0;
        for (int i = 0; i < 100; i++) begin @(posedge clk); #1; cyc++; end
        start = 1'b1;
        @(posedge clk); #1; cyc++; start = 1'b0;
        while (!ready && cyc < 5000) begin @(posedge clk); #1; cyc++; end
        check_int("R7 latency with busy start", cyc, LAT);
        read_ct(ct);
        check128("R7 busy start ignored", ct, 128'h3925841d02dc09fbdc118597196a0b32);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        test_reset();
        run_vec("R3 example vector", 128'h000102030405060708090a0b0c0d0e0f,
                128'h00112233445566778899aabbccddeeff,
                128'h69c4e0d86a7b0430d8cdb78070b4c55a, 1'b1);
        run_vec("R4 second vector", 128'h2b7e151628aed2a6abf7158809cf4f3c,
                128'h3243f6a8885a308d313198a2e0370734,
                128'h3925841d02dc09fbdc118597196a0b32, 1'b1);
        run_vec("R4 R8 zero vector", 128'h0, 128'h0,
                128'h66e94bd4ef8a2c3b884cfa59ca342b2e, 1'b1);
        test_back_to_back();
        test_busy_loads();
        test_busy_start();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule